// File: doc/BRIEF.md
# System Interrupt Router

The router collects 32 level-sensitive device interrupt lines into a registered pending word and turns every enabled pending line into a processor interrupt level. Source lines map to levels through a fixed, irregular table. Several sources can share one level, and they are merged into a single request bit. The merged level set is delivered to exactly one processor, chosen by software from up to 16. A global master-disable bit in the mask register withholds every hard level from every processor.

Software reaches the block through a word-addressed register port with a 3-bit word index and a single-cycle write strobe. The port offers five functions:
- read back the pending word;
- read back the writable part of the mask;
- a write-one-to-enable word;
- a write-one-to-disable word;
- the target processor number.

Reads are combinational from registered state. A separate broadcast output is high while any level-15 source line is pending, whatever the mask says. This output feeds the per-processor pending registers that sit outside the block.

Top module: `irq_router`

## Requirements
- R1: Source bits map to levels as follows, and an enabled pending source sets request bit (level) of the target processor:
  - level 2 from bits 0 and 7;
  - level 3 from bits 1 and 8;
  - level 4 from bit 18;
  - level 5 from bits 2 and 9;
  - level 6 from bit 16;
  - level 7 from bits 3 and 10;
  - level 8 from bit 20;
  - level 9 from bits 4, 11 and 21;
  - level 10 from bit 19;
  - level 11 from bits 5, 12 and 22;
  - level 12 from bits 14 and 15;
  - level 13 from bits 6, 13 and 17;
  - level 15 from bits 27 to 30.
- R2: Bits 23 to 26 and bit 31 have no level. Driving them changes neither the pending word nor any output.
- R3: The pending bit of a mapped source equals its input line as sampled at the previous rising edge. Reading word 0 returns the pending word with bit 31 always 0.
- R4: Reading word 1 returns the mask register ANDed with 0xF05DFF80.
- R5: Writing word 2 clears the mask bits where (wdata & 0xF05DFF80) is 1, which enables those sources. Writing word 3 sets those mask bits instead. Mask bits outside 0xF05DFF80 never change.
- R6: Masking a source leaves its pending bit unchanged and only stops its level from being forwarded.
- R7: Writing word 4 stores wdata[3:0] as the target. Reading word 4 returns the stored target, zero-extended.
- R8: While mask bit 31 is 1, every processor's request vector is zero.
- R9: Only the processor whose index equals the target receives levels. All other request vectors are zero.
- R10: The broadcast output is 1 exactly when any of pending bits 27 to 30 is 1. The mask and the master-disable bit do not affect it.
- R11: After reset the pending word is 0, the target is 0 and the mask is 0x0FA2007F, so word 1 reads 0.
- R12: Reads of words 2, 3, 5, 6 and 7 return 0. Writes to words 0, 1, 5, 6 and 7 change no state.
- R13: Request vectors, the broadcast output and read data reflect any input change or write in the cycle after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Level-sensitive device interrupt lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_req | output | 256 | 16-bit level-request vector per processor, processor c at bits [16c+15:16c] |
| lvl15_bcast | output | 1 | High while any level-15 source is pending |

## Verification
A source line or register write presented before rising edge k is visible at the request outputs, the broadcast output and the read data right after edge k, one edge later. Read data is combinational in the word index, so it shows the state left by that same edge. The bench drives inputs just after each falling edge. A behavioural model advances on the same rising edge, and every output is compared at the next falling edge, which is exactly one rising edge after the stimulus. Directed phases walk every source bit, exercise masking, steering and the master disable, and probe the undefined words. A final pseudo-random phase mixes line changes with writes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int SRC_N  = 32;
    localparam int LVL_N  = 16;
    localparam int DATA_W = 32;

    // Mask bits that are hard-wired to 1 and cannot be written.
    localparam logic [DATA_W-1:0] FIXED_DIS  = 32'h0FA2_007F;
    localparam logic [DATA_W-1:0] WR_MASK    = ~FIXED_DIS;
    localparam int                MASTER_BIT = 31;

    typedef enum logic [2:0] {
        W_PEND  = 3'd0,
        W_DISRD = 3'd1,
        W_ENA   = 3'd2,
        W_DIS   = 3'd3,
        W_TGT   = 3'd4
    } reg_word_e;

    // Processor level driven by one source line; 0 means unmapped.
    function automatic logic [3:0] src_level(input int b);
        logic [3:0] l;
        case (b)
            0, 7:          l = 4'd2;
            1, 8:          l = 4'd3;
            2, 9:          l = 4'd5;
            3, 10:         l = 4'd7;
            4, 11, 21:     l = 4'd9;
            5, 12, 22:     l = 4'd11;
            6, 13, 17:     l = 4'd13;
            14, 15:        l = 4'd12;
            16:            l = 4'd6;
            18:            l = 4'd4;
            19:            l = 4'd10;
            20:            l = 4'd8;
            27, 28, 29, 30: l = 4'd15;
            default:       l = 4'd0;
        endcase
        return l;
    endfunction

    // All source lines that feed a given level.
    function automatic logic [SRC_N-1:0] level_sources(input int lvl);
        logic [SRC_N-1:0] m;
        m = '0;
        for (int b = 0; b < SRC_N; b++) begin
            if (int'(src_level(b)) == lvl) m[b] = 1'b1;
        end
        return m;
    endfunction

    // Source lines that have a level at all.
    function automatic logic [SRC_N-1:0] live_sources();
        logic [SRC_N-1:0] m;
        m = '0;
        for (int b = 0; b < SRC_N; b++) begin
            if (src_level(b) != 4'd0) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_irq,
    output logic [SRC_N-1:0] pend,
    output logic             lvl15_any
);

    localparam logic [SRC_N-1:0] LIVE  = live_sources();
    localparam logic [SRC_N-1:0] TOP15 = level_sources(15);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= src_irq & LIVE;
        end
    end

    assign lvl15_any = |(pend & TOP15);

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int TGT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_N-1:0]  pend,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dis_q,
    output logic [TGT_W-1:0]  tgt_q
);

    logic [DATA_W-1:0] wbits;
    assign wbits = wdata & WR_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q <= FIXED_DIS;
            tgt_q <= '0;
        end else if (wr) begin
            unique case (addr)
                W_ENA:   dis_q <= dis_q & ~wbits;
                W_DIS:   dis_q <= dis_q | wbits;
                W_TGT:   tgt_q <= wdata[TGT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            W_PEND:  rdata = pend & ~(DATA_W'(1) << MASTER_BIT);
            W_DISRD: rdata = dis_q & WR_MASK;
            W_TGT:   rdata = DATA_W'(tgt_q);
            default: rdata = '0;
        endcase
    end

    // R5: a disable write leaves every written bit set
    p_dis_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == W_DIS) |=> ((dis_q & $past(wbits)) == $past(wbits)));

    // R5: an enable write leaves every written bit clear
    p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == W_ENA) |=> ((dis_q & $past(wbits)) == '0));

    // R7: a target write keeps the low bits of the data
    p_tgt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == W_TGT) |=> (tgt_q == $past(wdata[TGT_W-1:0])));

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_router_pkg::*;
(
    input  logic [SRC_N-1:0]  pend,
    input  logic [DATA_W-1:0] dis,
    output logic [LVL_N-1:0]  lvl_vec
);

    logic [SRC_N-1:0] live;
    assign live = pend & ~dis;

    for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
        if (l == 0) begin : g_none
            assign lvl_vec[l] = 1'b0;
        end else begin : g_or
            localparam logic [SRC_N-1:0] M = level_sources(l);
            assign lvl_vec[l] = |(live & M);
        end
    end

endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
    parameter int NUM_CPU = 16,
    parameter int LVL_N   = 16,
    parameter int TGT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LVL_N-1:0]         lvl_vec,
    input  logic [TGT_W-1:0]         tgt,
    input  logic                     master_off,
    output logic [NUM_CPU*LVL_N-1:0] cpu_req
);

    logic [NUM_CPU-1:0] hit;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign cpu_req[c*LVL_N +: LVL_N] =
            (!master_off && tgt == TGT_W'(c)) ? lvl_vec : '0;
        assign hit[c] = |cpu_req[c*LVL_N +: LVL_N];
    end

    // R8: master disable silences every processor
    p_master_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        master_off |-> (cpu_req == '0));

    // R9: at most one processor sees any level
    p_single_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int ADDR_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [31:0]              src_irq,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic [NUM_CPU*16-1:0]    cpu_req,
    output logic                     lvl15_bcast
);

    localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    logic [SRC_N-1:0]  pend;
    logic [DATA_W-1:0] dis;
    logic [TGT_W-1:0]  tgt;
    logic [LVL_N-1:0]  lvl_vec;

    irq_src_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .pend      (pend),
        .lvl15_any (lvl15_bcast)
    );

    irq_regfile #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .pend  (pend),
        .rdata (reg_rdata),
        .dis_q (dis),
        .tgt_q (tgt)
    );

    irq_level_map u_map (
        .pend    (pend),
        .dis     (dis),
        .lvl_vec (lvl_vec)
    );

    irq_steer #(
        .NUM_CPU (NUM_CPU),
        .LVL_N   (LVL_N),
        .TGT_W   (TGT_W)
    ) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_vec    (lvl_vec),
        .tgt        (tgt),
        .master_off (dis[MASTER_BIT]),
        .cpu_req    (cpu_req)
    );

endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  src_irq = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] cpu_req;
    logic         lvl15_bcast;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R11";

    logic [31:0] m_pend = '0;
    logic [31:0] m_dis = 32'h0FA2_007F;
    logic [3:0]  m_tgt = '0;

    always #5 clk = ~clk;

    irq_router u_irq_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_irq     (src_irq),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cpu_req     (cpu_req),
        .lvl15_bcast (lvl15_bcast)
    );

    function automatic int ref_lvl(input int b);
        int k;
        if (b < 14) begin
            k = b % 7;
            return (k == 0) ? 2 : 2 * k + 1;
        end
        if (b < 16) return 12;
        if (b == 16) return 6;
        if (b == 17) return 13;
        if (b == 18) return 4;
        if (b == 19) return 10;
        if (b == 20) return 8;
        if (b == 21) return 9;
        if (b == 22) return 11;
        if (b >= 27 && b <= 30) return 15;
        return 0;
    endfunction

    function automatic logic [31:0] ref_live();
        logic [31:0] m = '0;
        for (int b = 0; b < 32; b++) if (ref_lvl(b) != 0) m[b] = 1'b1;
        return m;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend <= '0;
            m_dis  <= 32'h0FA2_007F;
            m_tgt  <= '0;
        end else begin
            m_pend <= src_irq & ref_live();
            if (reg_wr) begin
                case (reg_addr)
                    3'd2: m_dis <= m_dis & ~(reg_wdata & 32'hF05D_FF80);
                    3'd3: m_dis <= m_dis | (reg_wdata & 32'hF05D_FF80);
                    3'd4: m_tgt <= reg_wdata[3:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [255:0] exp_req();
        logic [15:0]  v = '0;
        logic [255:0] r = '0;
        for (int b = 0; b < 32; b++)
            if (m_pend[b] && !m_dis[b] && ref_lvl(b) != 0) v[ref_lvl(b)] = 1'b1;
        if (!m_dis[31]) r[int'(m_tgt)*16 +: 16] = v;
        return r;
    endfunction

    function automatic logic [31:0] exp_rd();
        case (reg_addr)
            3'd0: return {1'b0, m_pend[30:0]};
            3'd1: return m_dis & 32'hF05D_FF80;
            3'd4: return {28'd0, m_tgt};
            default: return 32'd0;
        endcase
    endfunction

    task automatic compare();
        logic [255:0] er;
        logic [31:0]  ed;
        logic         eb;
        er = exp_req();
        ed = exp_rd();
        eb = |m_pend[30:27];
        total++;
        if (cpu_req !== er) begin
            bad++;
            $display("FAIL %s cpu_req act=%h exp=%h", tag, cpu_req, er);
        end
        total++;
        if (reg_rdata !== ed) begin
            bad++;
            $display("FAIL %s rdata word %0d act=%h exp=%h", tag, reg_addr, reg_rdata, ed);
        end
        total++;
        if (lvl15_bcast !== eb) begin
            bad++;
            $display("FAIL %s bcast act=%b exp=%b", tag, lvl15_bcast, eb);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a;
        cyc();
    endtask

    initial begin
        logic [31:0] lcg;
        // R11: reset state
        tag = "R11";
        repeat (2) cyc();
        rst_n = 1'b1;
        rd(3'd0); rd(3'd1); rd(3'd4);

        // R1 and R2: walk every source bit with all sources enabled
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd4, 32'd3);
        reg_addr = 3'd0;
        for (int b = 0; b < 32; b++) begin
            tag = (ref_lvl(b) == 0) ? "R2" : "R1";
            src_irq = 32'd1 << b;
            cyc(); cyc();
        end
        src_irq = '0;
        tag = "R2";
        src_irq = 32'h8780_0000;
        cyc(); rd(3'd0);

        // R3: pending readback with bit 31 driven
        tag = "R3";
        src_irq = 32'hFFFF_FFFF;
        rd(3'd0);
        src_irq = 32'h0001_4081;
        rd(3'd0);

        // R9: merged levels steered to one processor
        tag = "R9";
        src_irq = 32'h0000_0081;
        wr(3'd4, 32'd5); cyc();
        wr(3'd4, 32'd15); cyc();
        src_irq = 32'h0060_1830;
        cyc();

        // R7: target keeps the low four bits
        tag = "R7";
        wr(3'd4, 32'h0000_003A); rd(3'd4);
        wr(3'd4, 32'hFFFF_FFF1); rd(3'd4);

        // R5 and R4: set and clear mask bits, read mask back
        tag = "R5";
        wr(3'd3, 32'h0000_FF00); rd(3'd1);
        wr(3'd2, 32'h0000_0F00); rd(3'd1);
        tag = "R4";
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd1);
        wr(3'd2, 32'h7FFF_FFFF); rd(3'd1);

        // R6: masking keeps pending
        tag = "R6";
        src_irq = 32'h0000_0200;
        rd(3'd0);
        wr(3'd3, 32'h0000_0200); rd(3'd0);
        wr(3'd2, 32'h0000_0200); rd(3'd0);

        // R8: master disable
        tag = "R8";
        src_irq = 32'h7000_C200;
        wr(3'd3, 32'h8000_0000); cyc();
        wr(3'd2, 32'h8000_0000); cyc();

        // R10: broadcast follows level-15 lines regardless of mask
        tag = "R10";
        src_irq = 32'h0800_0000;
        cyc(); cyc();
        wr(3'd3, 32'h7000_0000);
        src_irq = 32'h2000_0000;
        cyc();
        src_irq = '0;
        cyc();
        wr(3'd2, 32'h7000_0000);

        // R12: undefined words
        tag = "R12";
        src_irq = 32'h0000_0F00;
        rd(3'd2); rd(3'd3); rd(3'd5); rd(3'd6); rd(3'd7);
        wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1); rd(3'd4); rd(3'd0);

        // R13: mixed pseudo-random traffic, compared every cycle
        tag = "R13";
        lcg = 32'h1234_5678;
        for (int i = 0; i < 80; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            src_irq = lcg ^ {lcg[15:0], lcg[31:16]};
            reg_wr = (lcg[3:2] != 2'b00);
            reg_addr = lcg[30:28];
            reg_wdata = {lcg[7:0], lcg[23:0]};
            cyc();
        end
        reg_wr = 1'b0;
        cyc();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R13 watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule